// File: doc/BRIEF.md
# Multiplexed Transmit Line Scanner

This block is the transmit-side scanner of an eight-line serial multiplexer. One shared scanner walks over the lines that the host has enabled. It stops on the first enabled line whose transmit holding buffer is empty. It then raises a ready flag and shows that line's number in a status word. The next character the host writes is routed to the line the scanner found. After that load the scanner moves on.

The search is round-robin. It starts from the line after the one served last, so no enabled line is starved. Each line transmitter has a holding register in front of its shift register. Because of this, the same line can be found again straight after a load, once its holding register has moved on. The scanner only runs while the master scan enable is high. A transmit interrupt follows the ready flag whenever the interrupt enable is set.

The host write is a valid/ready stream: `wr_ready` is the ready flag, and a character is taken only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` may drop without a transfer when the parked line is disabled or scanning is stopped; the host must hold `wr_valid` and `wr_data` until a transfer happens. Toward the line transmitters, each `ld_stb` bit is a one-cycle valid, and the matching `hold_empty` bit is that line's ready. The block never strobes a line whose `hold_empty` is low when it is selected.

Top module: `tx_line_scanner`

## Requirements
- R1: While reset is asserted and immediately after it, `wr_ready`, `tx_irq`, every `ld_stb` bit and the whole `status_word` are 0.
- R2: With `scan_en` low, `wr_ready` never rises, and a parked ready flag is withdrawn on the next clock edge.
- R3: The scanner parks only on line n where `line_en[n]` and `hold_empty[n]` were both 1 in the cycle before `wr_ready` rose. The status word then shows the line in bits 10:8 and the ready flag in bit 15; all other bits are 0.
- R4: The search starts at the line after the last line served and wraps modulo the line count; after reset the first line searched is line 0.
- R5: A transfer (`wr_valid` and `wr_ready` high at a clock edge) produces, in the following cycle, a one-cycle strobe on exactly the reported line's `ld_stb` bit, with `ld_data` equal to the written character.
- R6: A write offered while `wr_ready` is low has no effect: no strobe follows.
- R7: After a transfer, `wr_ready` is low for at least one cycle. The loaded line may be found again as soon as its `hold_empty` returns high; it is not selected in the cycle its strobe is active.
- R8: While `wr_ready` is high with no transfer, with `scan_en` high and the parked line still enabled, the flag and the reported line stay unchanged.
- R9: Clearing the parked line's enable bit withdraws `wr_ready` at the next edge without a strobe, and the scanner goes on to other enabled lines.
- R10: `tx_irq` is high exactly when `wr_ready` and `txie` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Master scan enable |
| txie | input | 1 | Transmit interrupt enable |
| line_en | input | 8 | Per-line transmit enable, bit n for line n |
| hold_empty | input | 8 | Per-line holding buffer empty (ready of each line) |
| wr_valid | input | 1 | Host character write valid |
| wr_data | input | 8 | Host character |
| wr_ready | output | 1 | Scanner ready flag, accepts the write |
| status_word | output | 16 | Bit 15 ready flag, bits 10:8 reported line, other bits 0 |
| tx_irq | output | 1 | Transmit interrupt request |
| ld_stb | output | 8 | Per-line one-cycle load strobe |
| ld_data | output | 8 | Character delivered with the strobe |

## Verification
A sweep with every line enabled and every buffer empty, writing on every ready cycle, must serve lines 0 to 7 in order. This separates a round-robin pointer from a fixed-priority search. A run with a single enabled line is the double-buffered pattern: the line has to be found again a few cycles after each load, which exposes any failure to re-arm or any wrong reselection while the strobe is still out. Directed withdrawal (disabling the parked line, dropping scan enable, writes while not ready) shows that a withdrawn flag never leaks a strobe. Long random runs with transmitters of different speeds and changing enables are compared cycle by cycle with a reference model, which catches misordering and stale-buffer overruns.

// File: rtl/txscan_pkg.sv
package txscan_pkg;
  localparam int STATUS_W = 16;
  localparam int RDY_POS  = 15;
  localparam int LINE_POS = 8;
endpackage

// File: rtl/txscan_pick.sv
// Round-robin search: first set bit of cand after position 'last', wrapping.
module txscan_pick #(
  parameter int N_LINES = 8,
  parameter int LW      = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] cand,
  input  logic [LW-1:0]      last,
  output logic               found,
  output logic [LW-1:0]      pick
);
  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= N_LINES; k++) begin
      int idx;
      idx = (int'(last) + k) % N_LINES;
      if (!found && cand[idx]) begin
        found = 1'b1;
        pick  = LW'(idx);
      end
    end
  end
endmodule

// File: rtl/txscan_ctrl.sv
// Park / hold / release state of the shared scanner.
module txscan_ctrl #(
  parameter int N_LINES = 8,
  parameter int LW      = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic [N_LINES-1:0] line_en,
  input  logic [N_LINES-1:0] hold_empty,
  input  logic [N_LINES-1:0] stb_mask,
  input  logic               wr_valid,
  output logic               rdy,
  output logic [LW-1:0]      cur,
  output logic               accept
);
  logic [LW-1:0]      last;
  logic [N_LINES-1:0] cand;
  logic               found;
  logic [LW-1:0]      pick;

  // a line whose strobe is in flight still shows a stale empty flag
  assign cand   = line_en & hold_empty & ~stb_mask;
  assign accept = rdy & wr_valid;

  txscan_pick #(.N_LINES(N_LINES), .LW(LW)) u_pick (
    .cand  (cand),
    .last  (last),
    .found (found),
    .pick  (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      cur  <= '0;
      last <= LW'(N_LINES - 1);
    end else if (accept) begin
      rdy  <= 1'b0;
      last <= cur;
    end else if (rdy) begin
      if (!scan_en || !line_en[cur]) rdy <= 1'b0;
    end else if (scan_en && found) begin
      rdy <= 1'b1;
      cur <= pick;
    end
  end
endmodule

// File: rtl/txscan_load.sv
// Steers an accepted character to one line as a one-cycle strobe.
module txscan_load #(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8,
  parameter int LW      = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [LW-1:0]      sel,
  input  logic [DATA_W-1:0]  data_in,
  output logic [N_LINES-1:0] stb,
  output logic [DATA_W-1:0]  data_out
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb[i] <= 1'b0;
      else        stb[i] <= accept && (sel == LW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_out <= '0;
    else if (accept) data_out <= data_in;
  end
endmodule

// File: rtl/tx_line_scanner.sv
module tx_line_scanner #(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             scan_en,
  input  logic                             txie,
  input  logic [N_LINES-1:0]               line_en,
  input  logic [N_LINES-1:0]               hold_empty,
  input  logic                             wr_valid,
  input  logic [DATA_W-1:0]                wr_data,
  output logic                             wr_ready,
  output logic [txscan_pkg::STATUS_W-1:0]  status_word,
  output logic                             tx_irq,
  output logic [N_LINES-1:0]               ld_stb,
  output logic [DATA_W-1:0]                ld_data
);
  import txscan_pkg::*;
  localparam int LW = $clog2(N_LINES);

  logic          rdy;
  logic          accept;
  logic [LW-1:0] cur;

  txscan_ctrl #(.N_LINES(N_LINES), .LW(LW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .line_en    (line_en),
    .hold_empty (hold_empty),
    .stb_mask   (ld_stb),
    .wr_valid   (wr_valid),
    .rdy        (rdy),
    .cur        (cur),
    .accept     (accept)
  );

  txscan_load #(.N_LINES(N_LINES), .DATA_W(DATA_W), .LW(LW)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .sel      (cur),
    .data_in  (wr_data),
    .stb      (ld_stb),
    .data_out (ld_data)
  );

  always_comb begin
    status_word = '0;
    status_word[RDY_POS] = rdy;
    status_word[LINE_POS +: LW] = cur;
  end

  assign wr_ready = rdy;
  assign tx_irq   = rdy & txie;
endmodule

// File: rtl/txscan_chk.sv
module txscan_chk #(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             scan_en,
  input logic                             txie,
  input logic [N_LINES-1:0]               line_en,
  input logic [N_LINES-1:0]               hold_empty,
  input logic                             wr_valid,
  input logic [DATA_W-1:0]                wr_data,
  input logic                             wr_ready,
  input logic [txscan_pkg::STATUS_W-1:0]  status_word,
  input logic                             tx_irq,
  input logic [N_LINES-1:0]               ld_stb,
  input logic [DATA_W-1:0]                ld_data
);
  import txscan_pkg::*;
  localparam int LW = $clog2(N_LINES);

  logic [LW-1:0]      line;
  logic [N_LINES-1:0] cand_q;
  assign line = status_word[LINE_POS +: LW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cand_q <= '0;
    else        cand_q <= line_en & hold_empty;
  end

  // R3
  park_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ready) |-> cand_q[line]);

  // R5
  load_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (ld_stb == (N_LINES'(1) << $past(line))) && (ld_data == $past(wr_data)));

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb));

  // R6
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> (ld_stb == '0));

  // R7
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid && scan_en && line_en[line]) |=> (wr_ready && $stable(line)));

  // R2
  scan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !wr_ready);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (wr_ready && txie));
endmodule

bind tx_line_scanner txscan_chk #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_tx_line_scanner.sv
`timescale 1ns/1ps
module sim_tx_line_scanner;
  localparam int N  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0, txie = 1'b0, wr_valid = 1'b0;
  logic [N-1:0]  line_en = '0;
  logic [DW-1:0] wr_data = '0;
  logic [N-1:0]  hold_full;
  logic [N-1:0]  hold_empty;
  logic          wr_ready, tx_irq;
  logic [15:0]   status_word;
  logic [N-1:0]  ld_stb;
  logic [DW-1:0] ld_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign hold_empty = ~hold_full;

  tx_line_scanner #(.N_LINES(N), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .txie(txie), .line_en(line_en),
    .hold_empty(hold_empty), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .status_word(status_word), .tx_irq(tx_irq), .ld_stb(ld_stb), .ld_data(ld_data));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rr_next(input logic [N-1:0] c, input int last);
    for (int s = 1; s <= N; s++) begin
      int i;
      i = (last + s) % N;
      if (c[i]) return i;
    end
    return -1;
  endfunction

  // reference model, built from the requirements
  logic          e_rdy;
  int            e_line, e_ptr;
  logic [N-1:0]  e_stb;
  logic [DW-1:0] e_data;

  always @(posedge clk) begin : model
    logic [N-1:0] cand;
    int p;
    if (!rst_n) begin
      e_rdy <= 0; e_line <= 0; e_ptr <= N-1; e_stb <= '0; e_data <= '0;
    end else if (wr_valid && e_rdy) begin
      e_stb <= N'(1) << e_line; e_data <= wr_data; e_rdy <= 0; e_ptr <= e_line;
    end else begin
      e_stb <= '0;
      if (e_rdy) begin
        if (!scan_en || !line_en[e_line]) e_rdy <= 0;
      end else begin
        cand = line_en & hold_empty & ~e_stb;
        p = rr_next(cand, e_ptr);
        if (scan_en && p >= 0) begin e_rdy <= 1; e_line <= p; end
      end
    end
  end

  // line transmitters: holding register in front of a shift register
  int shcnt [N];
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      logic nf; int ns;
      if (!rst_n) begin
        hold_full[i] <= 1'b0; shcnt[i] <= 0;
      end else begin
        nf = hold_full[i]; ns = shcnt[i];
        if (ns > 0) ns--;
        if (ns == 0 && nf) begin ns = 3 + i; nf = 0; end
        if (ld_stb[i]) begin
          chk(!hold_full[i], "R3 strobe into full holding buffer", i, 32'hff);
          nf = 1;
        end
        hold_full[i] <= nf; shcnt[i] <= ns;
      end
    end
  end

  // cycle comparison at posedge+4; stimulus changes at posedge+5
  bit cmp_on = 0;
  always @(posedge clk) begin
    #4;
    if (rst_n && cmp_on) begin
      chk(wr_ready == e_rdy, "R2/R8/R9 ready flag", wr_ready, e_rdy);
      if (e_rdy) chk(status_word[15] && status_word[10:8] == e_line[2:0],
                     "R3/R4 reported line", status_word, 32'h8000 | (e_line << 8));
      chk((status_word & 16'h78ff) == 0, "R3 unused status bits", status_word, 0);
      chk(ld_stb == e_stb, "R5/R6 load strobe", ld_stb, e_stb);
      if (e_stb != 0) chk(ld_data == e_data, "R5 load data", ld_data, e_data);
      chk(tx_irq == (e_rdy & txie), "R10 interrupt", tx_irq, e_rdy & txie);
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wait_strobe(output int idx, output int cyc);
    cyc = 0;
    do begin tick(); cyc++; end while (ld_stb == 0);
    idx = -1;
    for (int i = 0; i < N; i++) if (ld_stb[i]) idx = i;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int idx, cyc, cnt_r, cnt_s;
    void'($urandom(32'h1a2b3c));
    tick(); tick();
    // R1 during reset
    chk(wr_ready == 0 && tx_irq == 0, "R1 flags in reset", {wr_ready, tx_irq}, 0);
    chk(ld_stb == 0 && status_word == 0, "R1 strobes/status in reset", {ld_stb, status_word}, 0);
    rst_n = 1'b1; cmp_on = 1;
    tick();
    chk(wr_ready == 0 && ld_stb == 0 && status_word == 0, "R1 after reset", status_word, 0);

    // R2 / R6: no scanning, writes offered while not ready
    line_en = '1; txie = 1;
    cnt_r = 0; cnt_s = 0;
    for (int c = 0; c < 20; c++) begin
      wr_valid = c[0]; wr_data = 8'(c);
      tick();
      if (wr_ready) cnt_r++;
      if (ld_stb != 0) cnt_s++;
    end
    chk(cnt_r == 0, "R2 ready with scan off", cnt_r, 0);
    chk(cnt_s == 0, "R6 strobe from write while not ready", cnt_s, 0);

    // R4: all lines empty and enabled, continuous writes -> 0..7 in order
    wr_valid = 1; scan_en = 1;
    for (int k = 0; k < N; k++) begin
      wr_data = 8'(8'h40 + k);
      wait_strobe(idx, cyc);
      chk(idx == k, "R4 round-robin order", idx, k);
      chk(ld_data == 8'(8'h40 + k), "R5 data of sweep", ld_data, 8'h40 + k);
    end

    // R7: single line, double buffered -> found again soon after a load
    wr_valid = 0; line_en = 8'h20;
    repeat (20) tick();
    chk(wr_ready && status_word[10:8] == 3'd5, "R3 parked on only enabled line", status_word, 16'h8500);
    wr_valid = 1; wr_data = 8'hA5;
    wait_strobe(idx, cyc);
    chk(idx == 5, "R7 first load line", idx, 5);
    wr_data = 8'h5A;
    wait_strobe(idx, cyc);
    chk(idx == 5, "R7 second load line", idx, 5);
    chk(cyc <= 5, "R7 reload latency", cyc, 5);

    // R9: withdraw parked line by clearing its enable
    wr_valid = 0; line_en = 8'h0C;
    repeat (12) tick();
    chk(wr_ready && status_word[10:8] == 3'd2, "R9 parked on line 2", status_word, 16'h8200);
    line_en = 8'h08;
    tick();
    chk(!wr_ready, "R9 withdraw on disable", wr_ready, 0);
    tick(); tick();
    chk(wr_ready && status_word[10:8] == 3'd3, "R9 moves to line 3", status_word, 16'h8300);
    scan_en = 0;
    tick();
    chk(!wr_ready, "R2 withdraw on scan off", wr_ready, 0);

    // random phase, checked by the reference model every cycle
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 8 == 0) line_en = N'($urandom);
      scan_en  = ($urandom % 16) != 0;
      txie     = $urandom % 2;
      wr_valid = $urandom % 2;
      wr_data  = DW'($urandom);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule